// File: doc/BRIEF.md
# Text-Mode Character Display Renderer

This block turns a grid of 80 columns by 30 rows of character cells into a pixel stream for a 640×480 raster. A separate timing generator supplies the current pixel coordinates and an active-area flag each clock. The renderer uses the coordinates to select a cell, reads that cell's word from an internal video RAM, builds the glyph row for the cell's character code and the current line, and picks the one bit that belongs to the current pixel. It then turns that bit into a 12-bit RGB value.

Each cell word holds a character code, a foreground and a background palette index, and an inverse flag. In colour mode the foreground and background entries of a 16-entry palette give the colours. In monochrome mode a lit pixel is white and an unlit pixel is black. The inverse flag swaps the two in both modes. A host fills the video RAM through a plain address/data/write-enable port. The palette has its own write port. The lookup takes two register stages, and the active flag and the mode travel with the pixel, so the output stays aligned with its pixel.

Top module: `txtr_render`

## Requirements
- R1: While reset is high and on the first clock after it, `rgb_out` is 0 and `vis_out` is 0. All 16 palette entries reset to 0.
- R2: A host write with `hw_we` high stores `hw_data` at linear address row*80+col. A write to an address of 2400 or more is dropped. The word layout is: bit 15 is inverse, bits 14..11 are the foreground index, bits 10..7 are the background index, and bits 6..0 are the character code.
- R3: Pixel (x,y) belongs to column x[9:3] and row y[8:4]. The glyph line is y[3:0], and the pixel uses glyph bit 7−x[2:0], so bit 7 is the leftmost pixel of a cell.
- R4: The built-in font gives glyph byte {code,1} XOR {line,line} for a 7-bit code and a 4-bit line.
- R5: In monochrome mode (`color_en`=0) the output is 12'hFFF when glyph bit XOR inverse is 1, and 12'h000 when it is 0.
- R6: In colour mode (`color_en`=1) the output is palette[fg] when glyph bit XOR inverse is 1, and palette[bg] when it is 0.
- R7: When the delayed active flag is low, `rgb_out` is 0 whatever the mode, cell or palette.
- R8: `vis_out` and `rgb_out` belong to the coordinates, active flag and mode sampled two clock edges earlier, and a new pixel is accepted every clock.
- R9: `pal_we` writes `pal_rgb` into palette entry `pal_idx`. The new value appears in the output from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_x | input | 10 | Horizontal pixel coordinate |
| pix_y | input | 10 | Vertical pixel coordinate |
| pix_vis | input | 1 | Coordinate lies in the active area |
| color_en | input | 1 | 1 selects colour mode, 0 selects monochrome |
| hw_we | input | 1 | Video RAM write enable |
| hw_addr | input | 12 | Video RAM linear cell address |
| hw_data | input | 16 | Cell word to write |
| pal_we | input | 1 | Palette write enable |
| pal_idx | input | 4 | Palette entry to write |
| pal_rgb | input | 12 | Palette colour to write |
| rgb_out | output | 12 | Pixel colour, 4 bits each of R, G, B |
| vis_out | output | 1 | Active flag aligned with `rgb_out` |

## Verification
A vector table probes four written cells at the first and last cell of the screen and in the middle. It uses pixels whose glyph bit is set and pixels whose bit is clear, with and without the inverse flag, and the same pixel in both modes. This separates a wrong bit order, a wrong row or column decode and a foreground/background swap. A burst of consecutive pixels, one per clock, across two neighbouring cells checks the two-cycle alignment, because a skew of one stage shows up as a shifted bit. Directed cases cover the blanked area, a palette rewrite that must recolour a pixel, and a write beyond the last cell that must not land anywhere visible.

// File: rtl/txtr_pkg.sv
package txtr_pkg;

    localparam int COLS    = 80;
    localparam int ROWS    = 30;
    localparam int CELL_W  = 8;
    localparam int CELL_H  = 16;
    localparam int CELLS   = COLS * ROWS;
    localparam int ADDR_W  = $clog2(CELLS);
    localparam int CODE_W  = 7;
    localparam int IDX_W   = 4;
    localparam int PAL_N   = 1 << IDX_W;
    localparam int RGB_W   = 12;
    localparam int XSUB_W  = $clog2(CELL_W);
    localparam int LINE_W  = $clog2(CELL_H);
    localparam int WORD_W  = 1 + 2 * IDX_W + CODE_W;

    // cell word: inverse on top, then fg, bg, code
    typedef struct packed {
        logic              inv;
        logic [IDX_W-1:0]  fg;
        logic [IDX_W-1:0]  bg;
        logic [CODE_W-1:0] code;
    } cell_t;

    // per-pixel side information that rides along the pipeline
    typedef struct packed {
        logic              vis;
        logic              color;
        logic [XSUB_W-1:0] sub;
        logic [LINE_W-1:0] line;
    } tag_t;

    // computed font: one byte per (code, line)
    function automatic logic [CELL_W-1:0] glyph_row(input logic [CODE_W-1:0] code,
                                                    input logic [LINE_W-1:0] line);
        return {code, 1'b1} ^ {line, line};
    endfunction

    // linear cell address; out-of-grid coordinates fold to cell 0
    function automatic logic [ADDR_W-1:0] cell_addr(input logic [6:0] col,
                                                    input logic [5:0] row);
        if (32'(col) >= COLS || 32'(row) >= ROWS)
            return '0;
        return ADDR_W'(32'(row) * COLS + 32'(col));
    endfunction

endpackage

// File: rtl/txtr_vram.sv
module txtr_vram
    import txtr_pkg::*;
#(
    parameter int DEPTH = CELLS,
    parameter int AW    = ADDR_W,
    parameter int DW    = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && waddr < AW'(DEPTH))
            mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= mem[raddr];
    end

    // R2: reads only ever address stored cells
    a_r2_raddr_range: assert property (@(posedge clk) disable iff (rst)
        raddr < AW'(DEPTH));

endmodule

// File: rtl/txtr_glyph.sv
module txtr_glyph
    import txtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cell_t             cell_i,
    input  tag_t              tag_i,
    output logic [CELL_W-1:0] bits_o,
    output cell_t             cell_o,
    output tag_t              tag_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_o <= '0;
            cell_o <= '0;
            tag_o  <= '0;
        end else begin
            bits_o <= glyph_row(cell_i.code, tag_i.line);
            cell_o <= cell_i;
            tag_o  <= tag_i;
        end
    end

    // R4: blank flag passes the font stage unchanged
    a_r4_tag_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> tag_o.vis == $past(tag_i.vis));

endmodule

// File: rtl/txtr_palette.sv
module txtr_palette
    import txtr_pkg::*;
#(
    parameter int N  = PAL_N,
    parameter int IW = IDX_W,
    parameter int CW = RGB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [CW-1:0] wrgb,
    input  logic [IW-1:0] ridx_a,
    input  logic [IW-1:0] ridx_b,
    output logic [CW-1:0] rgb_a,
    output logic [CW-1:0] rgb_b
);

    logic [CW-1:0] ent [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent[i] <= '0;
            else if (we && widx == IW'(i))
                ent[i] <= wrgb;
        end
    end

    assign rgb_a = ent[ridx_a];
    assign rgb_b = ent[ridx_b];

    // R9: a written entry reads back the written colour on the next clock
    a_r9_pal_write: assert property (@(posedge clk) disable iff (rst)
        we |=> ent[$past(widx)] == $past(wrgb));

endmodule

// File: rtl/txtr_render.sv
module txtr_render
    import txtr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [9:0]  pix_x,
    input  logic [9:0]  pix_y,
    input  logic        pix_vis,
    input  logic        color_en,
    input  logic        hw_we,
    input  logic [11:0] hw_addr,
    input  logic [15:0] hw_data,
    input  logic        pal_we,
    input  logic [3:0]  pal_idx,
    input  logic [11:0] pal_rgb,
    output logic [11:0] rgb_out,
    output logic        vis_out
);

    localparam logic [RGB_W-1:0] WHITE = '1;

    // stage 0: address and tag from coordinates
    logic [ADDR_W-1:0] rd_addr;
    tag_t              tag_s0;

    always_comb begin
        rd_addr      = cell_addr(pix_x[9:3], pix_y[9:4]);
        tag_s0.vis   = pix_vis;
        tag_s0.color = color_en;
        tag_s0.sub   = pix_x[XSUB_W-1:0];
        tag_s0.line  = pix_y[LINE_W-1:0];
    end

    // stage 1: cell word out of video RAM, tag delayed to match
    logic [WORD_W-1:0] word_s1;
    tag_t              tag_s1;

    txtr_vram u_vram (
        .clk   (clk),
        .rst   (rst),
        .we    (hw_we),
        .waddr (hw_addr),
        .wdata (hw_data),
        .raddr (rd_addr),
        .rdata (word_s1)
    );

    always_ff @(posedge clk) begin
        if (rst)
            tag_s1 <= '0;
        else
            tag_s1 <= tag_s0;
    end

    // stage 2: glyph byte
    logic [CELL_W-1:0] bits_s2;
    cell_t             cell_s2;
    tag_t              tag_s2;

    txtr_glyph u_glyph (
        .clk    (clk),
        .rst    (rst),
        .cell_i (cell_t'(word_s1)),
        .tag_i  (tag_s1),
        .bits_o (bits_s2),
        .cell_o (cell_s2),
        .tag_o  (tag_s2)
    );

    // palette lookup for both candidate colours
    logic [RGB_W-1:0] fg_rgb, bg_rgb;

    txtr_palette u_pal (
        .clk    (clk),
        .rst    (rst),
        .we     (pal_we),
        .widx   (pal_idx),
        .wrgb   (pal_rgb),
        .ridx_a (cell_s2.fg),
        .ridx_b (cell_s2.bg),
        .rgb_a  (fg_rgb),
        .rgb_b  (bg_rgb)
    );

    // colour composition
    logic lit;

    always_comb begin
        lit = bits_s2[(CELL_W - 1) - int'(tag_s2.sub)] ^ cell_s2.inv;
        if (!tag_s2.vis)
            rgb_out = '0;
        else if (tag_s2.color)
            rgb_out = lit ? fg_rgb : bg_rgb;
        else
            rgb_out = lit ? WHITE : '0;
        vis_out = tag_s2.vis;
    end

    // settle counter so history checks never reach before reset release
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)
            warm <= '0;
        else if (warm != 2'd3)
            warm <= warm + 2'd1;
    end

    // R7: blanked pixels are black
    a_r7_blank_black: assert property (@(posedge clk) disable iff (rst)
        !vis_out |-> rgb_out == '0);

    // R5: monochrome output is only black or white
    a_r5_mono_levels: assert property (@(posedge clk) disable iff (rst)
        (vis_out && !tag_s2.color) |-> (rgb_out == '0 || rgb_out == WHITE));

    // R6: colour output is one of the two palette picks of the cell
    a_r6_color_pick: assert property (@(posedge clk) disable iff (rst)
        (vis_out && tag_s2.color) |-> (rgb_out == fg_rgb || rgb_out == bg_rgb));

    // R8: active flag emerges two clocks after it was presented
    a_r8_latency: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> vis_out == $past(pix_vis, 2));

    // R1: first clock after reset shows nothing
    a_r1_reset_dark: assert property (@(posedge clk)
        $past(rst) |-> (rgb_out == '0 && !vis_out));

endmodule

// File: tb/txtr_render_test.sv
module txtr_render_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  pix_x, pix_y;
    logic        pix_vis, color_en;
    logic        hw_we;
    logic [11:0] hw_addr;
    logic [15:0] hw_data;
    logic        pal_we;
    logic [3:0]  pal_idx;
    logic [11:0] pal_rgb;
    logic [11:0] rgb_out;
    logic        vis_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] shadow [2400];
    logic [11:0] pal_m  [16];

    always #10 clk = ~clk;

    txtr_render uut (
        .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y), .pix_vis(pix_vis),
        .color_en(color_en), .hw_we(hw_we), .hw_addr(hw_addr), .hw_data(hw_data),
        .pal_we(pal_we), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
        .rgb_out(rgb_out), .vis_out(vis_out)
    );

    // {vis, color, x, y}
    localparam logic [21:0] VEC [12] = '{
        {1'b1, 1'b0, 10'd0,   10'd0  },
        {1'b1, 1'b0, 10'd7,   10'd0  },
        {1'b1, 1'b1, 10'd0,   10'd0  },
        {1'b1, 1'b1, 10'd7,   10'd0  },
        {1'b1, 1'b0, 10'd639, 10'd479},
        {1'b1, 1'b1, 10'd632, 10'd470},
        {1'b1, 1'b0, 10'd42,  10'd53 },
        {1'b1, 1'b1, 10'd42,  10'd53 },
        {1'b1, 1'b1, 10'd45,  10'd60 },
        {1'b1, 1'b0, 10'd321, 10'd245},
        {1'b1, 1'b1, 10'd321, 10'd245},
        {1'b1, 1'b1, 10'd326, 10'd250}
    };

    function automatic logic [11:0] model(input logic [9:0] x, input logic [9:0] y,
                                          input logic vis, input logic col);
        logic [15:0] w;
        logic [7:0]  g;
        logic        b;
        if (!vis) return 12'h000;
        w = shadow[int'(y[8:4]) * 80 + int'(x[9:3])];
        g = {w[6:0], 1'b1} ^ {y[3:0], y[3:0]};
        b = g[7 - int'(x[2:0])] ^ w[15];
        if (col) return b ? pal_m[w[14:11]] : pal_m[w[10:7]];
        return b ? 12'hFFF : 12'h000;
    endfunction

    task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_cell(input int addr, input logic [15:0] w);
        @(negedge clk);
        hw_we = 1'b1; hw_addr = 12'(addr); hw_data = w;
        @(negedge clk);
        hw_we = 1'b0;
        if (addr < 2400) shadow[addr] = w;
    endtask

    task automatic wr_pal(input int i, input logic [11:0] c);
        @(negedge clk);
        pal_we = 1'b1; pal_idx = 4'(i); pal_rgb = c;
        @(negedge clk);
        pal_we = 1'b0;
        pal_m[i] = c;
    endtask

    // present one pixel and read the result two edges later
    task automatic probe(input logic [9:0] x, input logic [9:0] y, input logic v,
                         input logic c, input string req);
        @(negedge clk);
        pix_x = x; pix_y = y; pix_vis = v; color_en = c;
        @(negedge clk);
        @(negedge clk);
        check(req, rgb_out, model(x, y, v, c));
        check(req, {11'd0, vis_out}, {11'd0, v});
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pix_x = '0; pix_y = '0; pix_vis = 1'b1; color_en = 1'b1;
        hw_we = 1'b0; hw_addr = '0; hw_data = '0;
        pal_we = 1'b0; pal_idx = '0; pal_rgb = '0;
        for (int i = 0; i < 16; i++) pal_m[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rgb in reset", rgb_out, 12'h000);
        check("R1 vis in reset", {11'd0, vis_out}, 12'h000);
        rst = 1'b0;
        pix_vis = 1'b0;

        // clear video RAM (R2)
        for (int a = 0; a < 2400; a++) begin
            @(negedge clk);
            hw_we = 1'b1; hw_addr = 12'(a); hw_data = '0;
            shadow[a] = '0;
        end
        @(negedge clk);
        hw_we = 1'b0;
        // R1: palette starts at zero, so colour mode shows black
        probe(10'd3, 10'd3, 1'b1, 1'b1, "R1 palette reset");

        for (int i = 0; i < 16; i++)
            wr_pal(i, {4'(i), ~4'(i), 4'(i) ^ 4'h5});

        // R2: cells at corners and middle, inverse mixed
        wr_cell(0,            {1'b0, 4'd3, 4'd9,  7'h41});
        wr_cell(29 * 80 + 79, {1'b1, 4'd12, 4'd1, 7'h7F});
        wr_cell(3 * 80 + 5,   {1'b1, 4'd6, 4'd2,  7'h2A});
        wr_cell(15 * 80 + 40, {1'b0, 4'd15, 4'd0, 7'h55});
        wr_cell(15 * 80 + 39, {1'b1, 4'd7, 4'd8,  7'h13});

        // R3 R4 R5 R6: vector table
        for (int k = 0; k < 12; k++)
            probe(VEC[k][19:10], VEC[k][9:0], VEC[k][21], VEC[k][20],
                  VEC[k][20] ? "R6 R3 R4 colour vector" : "R5 R3 R4 mono vector");

        // R7: blanked pixel over a lit cell in both modes
        probe(10'd42, 10'd53, 1'b0, 1'b1, "R7 blank colour");
        probe(10'd42, 10'd53, 1'b0, 1'b0, "R7 blank mono");

        // R9: palette rewrite recolours the next output
        wr_pal(3, 12'hA5C);
        probe(10'd0, 10'd0, 1'b1, 1'b1, "R9 palette rewrite");

        // R2: write beyond last cell is dropped; cell 0 and last cell unchanged
        wr_cell(2400, 16'hFFFF);
        probe(10'd0, 10'd0, 1'b1, 1'b1, "R2 out of range write");
        probe(10'd639, 10'd479, 1'b1, 1'b1, "R2 out of range write");

        // R8: one pixel per clock across cells 39/40 of row 15, alternating mode
        begin
            logic [9:0] hx [16];
            logic       hc [16];
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                if (i >= 2)
                    check("R8 streaming alignment", rgb_out,
                          model(hx[i - 2], 10'd245, 1'b1, hc[i - 2]));
                hx[i] = 10'(312 + i);
                hc[i] = i[1];
                pix_x = hx[i]; pix_y = 10'd245; pix_vis = 1'b1; color_en = hc[i];
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule